// File: doc/BRIEF.md
# I2C Slave Address Matcher with Bus Status

This block is the front end of an I2C slave. It synchronizes the SCL and SDA lines into the core clock and recognises Start, Repeated Start and Stop conditions. It shifts in the first byte after each Start and compares the 7-bit address in that byte against a programmed own address. A per-bit don't-care mask takes part in the compare, and the block latches the read/write direction from the same byte.

When the address matches, the block acknowledges it. In a write it then takes in data bytes into a receive register and acknowledges each one. In a read it shifts out a byte that software has placed in a transmit register, most significant bit first. When the address does not match, the block lets go of the bus and waits for the next Start.

A small status set reports to software. Two flags give the most recent bus condition, one gives the transfer direction, and two give receive-full and transmit-full. Software reads and writes through single-cycle strobes.

Top module: `i2cs_addr_status`

## Requirements
- R1: `stat_stop` is 1 when the latest bus condition seen was a Stop (SDA rising while SCL is high) and 0 after any Start or Repeated Start.
- R2: `stat_start` is 1 when the latest bus condition seen was a Start or Repeated Start (SDA falling while SCL is high) and 0 after a Stop.
- R3: After every address byte, `stat_read` takes the eighth bit of that byte. 1 means read (data out of the slave) and 0 means write. This holds whether or not the address matched.
- R4: The seven bits before the direction bit, MSB first, are compared with `own_addr[6:0]`. A bit where mask bit k (k in 0..6) is 1 is not compared. Mask bits 9..7 have no effect on the 7-bit compare.
- R5: On a match, `sda_pull_low` is 1 during the ninth SCL clock of the address byte, which acknowledges it.
- R6: On a mismatch, `sda_pull_low` stays 0 and no byte is loaded until the next Start.
- R7: After a matched write address, each further byte is placed in `rx_data` and sets `stat_rx_full`, and the slave acknowledges it. A one-cycle `rx_rd` pulse clears `stat_rx_full`. A load in the same cycle as `rx_rd` wins.
- R8: A `tx_wr` pulse stores `tx_data` and sets `stat_tx_full`. After a matched read address, the stored byte is driven MSB first, where a 0 bit is shown as `sda_pull_low`=1. `stat_tx_full` clears when the eighth bit has been clocked out.
- R9: The 16-bit mask register is written with `mask_wr`. Bits 9..0 are stored, and `mask_rdata` bits 15..10 always read 0.
- R10: After reset all five status flags are 0, `sda_pull_low` is 0 and the mask reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen on the pin |
| sda_in | input | 1 | Bus data line as seen on the pin |
| sda_pull_low | output | 1 | 1 pulls SDA low (open-drain drive) |
| own_addr | input | 7 | Slave address to respond to |
| mask_wr | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 16 | Mask write value |
| mask_rdata | output | 16 | Mask readback, upper six bits zero |
| rx_rd | input | 1 | Software read strobe of the receive register |
| rx_data | output | 8 | Last received data byte |
| tx_wr | input | 1 | Software write strobe of the transmit register |
| tx_data | input | 8 | Byte to transmit |
| stat_stop | output | 1 | Latest condition was a Stop |
| stat_start | output | 1 | Latest condition was a Start or Repeated Start |
| stat_read | output | 1 | Direction from the last address byte |
| stat_rx_full | output | 1 | Receive register holds an unread byte |
| stat_tx_full | output | 1 | Transmit register holds an unsent byte |

## Verification
A wrong link state shows on the bus during the very next ninth clock. Either an acknowledge is missing or one is spurious, and in a read the data bits come out shifted or inverted. Both are visible within one byte time. A wrong match decision moves `stat_rx_full` and `rx_data` by the end of the following byte. Flag faults show a few core cycles after the bus condition that should have updated them, and the bench samples the flags after every Start, Stop, address and data byte.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
package i2cs_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } link_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic stop_seen;
        logic start_seen;
        logic read_dir;
        logic rx_full;
        logic tx_full;
    } status_t;

    function automatic logic addr_hit(input logic [ADDR_W-1:0] got,
                                      input logic [ADDR_W-1:0] own,
                                      input logic [ADDR_W-1:0] dont_care);
        return ((got ^ own) & ~dont_care) == '0;
    endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
`timescale 1ns/1ps
module i2cs_line_sync
    import i2cs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q, scl_now, sda_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_q    <= scl_now;
            sda_q    <= sda_now;
        end
    end

    assign scl_now     = scl_pipe[STAGES-1];
    assign sda_now     = sda_pipe[STAGES-1];
    assign ev.start    = scl_now & scl_q & sda_q & ~sda_now;
    assign ev.stop     = scl_now & scl_q & ~sda_q & sda_now;
    assign ev.scl_rise = scl_now & ~scl_q;
    assign ev.scl_fall = ~scl_now & scl_q;
    assign ev.sda      = sda_now;
endmodule

// File: rtl/i2cs_mask_reg.sv
`timescale 1ns/1ps
module i2cs_mask_reg #(
    parameter int REG_W  = 16,
    parameter int MASK_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [MASK_W-1:0] mask,
    output logic [REG_W-1:0]  rd_data
);
    always_ff @(posedge clk) begin
        if (rst)        mask <= '0;
        else if (wr_en) mask <= wr_data[MASK_W-1:0];
    end

    assign rd_data = REG_W'(mask);

    assert_mask_readback_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data == REG_W'($past(wr_data[MASK_W-1:0])));
endmodule

// File: rtl/i2cs_status.sv
`timescale 1ns/1ps
module i2cs_status
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              dir_load,
    input  logic              dir_val,
    input  logic              rx_load,
    input  logic              rx_rd,
    input  logic              tx_wr,
    input  logic [BYTE_W-1:0] tx_byte_in,
    input  logic              tx_done,
    output status_t           st,
    output logic [BYTE_W-1:0] tx_buf
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= '0;
            tx_buf <= '0;
        end else begin
            if (ev_start) begin
                st.start_seen <= 1'b1;
                st.stop_seen  <= 1'b0;
            end else if (ev_stop) begin
                st.start_seen <= 1'b0;
                st.stop_seen  <= 1'b1;
            end
            if (dir_load)   st.read_dir <= dir_val;
            if (rx_load)    st.rx_full  <= 1'b1;
            else if (rx_rd) st.rx_full  <= 1'b0;
            if (tx_wr) begin
                st.tx_full <= 1'b1;
                tx_buf     <= tx_byte_in;
            end else if (tx_done) begin
                st.tx_full <= 1'b0;
            end
        end
    end

    assert_start_flag_R2: assert property (@(posedge clk) disable iff (rst)
        ev_start |=> st.start_seen && !st.stop_seen);
    assert_stop_flag_R1: assert property (@(posedge clk) disable iff (rst)
        (ev_stop && !ev_start) |=> st.stop_seen && !st.start_seen);
    assert_dir_latch_R3: assert property (@(posedge clk) disable iff (rst)
        dir_load |=> st.read_dir == $past(dir_val));
    assert_rx_set_R7: assert property (@(posedge clk) disable iff (rst)
        rx_load |=> st.rx_full);
    assert_tx_set_R8: assert property (@(posedge clk) disable iff (rst)
        tx_wr |=> st.tx_full);
    assert_tx_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (tx_done && !tx_wr) |=> !st.tx_full);
endmodule

// File: rtl/i2cs_link_fsm.sv
`timescale 1ns/1ps
module i2cs_link_fsm
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [ADDR_W-1:0] dont_care,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              pull_low,
    output logic              dir_load,
    output logic              dir_val,
    output logic              rx_load,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              tx_done
);
    link_state_e       state;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] shreg, txsh;
    logic              master_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            bitcnt     <= '0;
            shreg      <= '0;
            txsh       <= '0;
            master_ack <= 1'b0;
            pull_low   <= 1'b0;
            dir_load   <= 1'b0;
            dir_val    <= 1'b0;
            rx_load    <= 1'b0;
            rx_byte    <= '0;
            tx_done    <= 1'b0;
        end else begin
            dir_load <= 1'b0;
            rx_load  <= 1'b0;
            tx_done  <= 1'b0;
            if (ev.start) begin
                state    <= ST_ADDR;
                bitcnt   <= '0;
                pull_low <= 1'b0;
            end else if (ev.stop) begin
                state    <= ST_IDLE;
                pull_low <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (ev.scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], ev.sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (ev.scl_fall && bitcnt == 4'd8) begin
                            dir_load <= 1'b1;
                            dir_val  <= shreg[0];
                            if (addr_hit(shreg[BYTE_W-1:1], own_addr, dont_care)) begin
                                pull_low <= 1'b1;
                                state    <= ST_AACK;
                            end else begin
                                state    <= ST_SKIP;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (ev.scl_fall) begin
                            bitcnt <= '0;
                            if (shreg[0]) begin
                                state    <= ST_RDATA;
                                txsh     <= tx_byte;
                                pull_low <= ~tx_byte[BYTE_W-1];
                            end else begin
                                state    <= ST_WDATA;
                                pull_low <= 1'b0;
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (ev.scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], ev.sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (ev.scl_fall && bitcnt == 4'd8) begin
                            rx_load  <= 1'b1;
                            rx_byte  <= shreg;
                            pull_low <= 1'b1;
                            state    <= ST_WACK;
                        end
                    end
                    ST_WACK: begin
                        if (ev.scl_fall) begin
                            pull_low <= 1'b0;
                            bitcnt   <= '0;
                            state    <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (ev.scl_fall) begin
                            bitcnt <= bitcnt + 4'd1;
                            if (bitcnt == 4'd7) begin
                                pull_low <= 1'b0;
                                tx_done  <= 1'b1;
                                state    <= ST_RACK;
                            end else begin
                                txsh     <= {txsh[BYTE_W-2:0], 1'b0};
                                pull_low <= ~txsh[BYTE_W-2];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev.scl_rise) begin
                            master_ack <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (master_ack) begin
                                state    <= ST_RDATA;
                                bitcnt   <= '0;
                                txsh     <= tx_byte;
                                pull_low <= ~tx_byte[BYTE_W-1];
                            end else begin
                                state    <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_skip_released_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP) |-> !pull_low && !rx_load);
    assert_ack_drive_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_AACK) |-> pull_low);
    assert_start_resets_link_R2: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (state == ST_ADDR) && !pull_low);
endmodule

// File: rtl/i2cs_addr_status.sv
`timescale 1ns/1ps
module i2cs_addr_status
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MASK_REG_W  = 16,
    parameter int MASK_W      = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  sda_pull_low,
    input  logic [ADDR_W-1:0]     own_addr,
    input  logic                  mask_wr,
    input  logic [MASK_REG_W-1:0] mask_wdata,
    output logic [MASK_REG_W-1:0] mask_rdata,
    input  logic                  rx_rd,
    output logic [BYTE_W-1:0]     rx_data,
    input  logic                  tx_wr,
    input  logic [BYTE_W-1:0]     tx_data,
    output logic                  stat_stop,
    output logic                  stat_start,
    output logic                  stat_read,
    output logic                  stat_rx_full,
    output logic                  stat_tx_full
);
    bus_ev_t           ev;
    status_t           st;
    logic [MASK_W-1:0] mask;
    logic [BYTE_W-1:0] tx_buf;
    logic              dir_load, dir_val, rx_load, tx_done;

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .ev(ev)
    );

    i2cs_mask_reg #(.REG_W(MASK_REG_W), .MASK_W(MASK_W)) u_mask (
        .clk(clk), .rst(rst), .wr_en(mask_wr), .wr_data(mask_wdata),
        .mask(mask), .rd_data(mask_rdata)
    );

    i2cs_link_fsm u_link (
        .clk(clk), .rst(rst), .ev(ev), .own_addr(own_addr),
        .dont_care(mask[ADDR_W-1:0]), .tx_byte(tx_buf),
        .pull_low(sda_pull_low), .dir_load(dir_load), .dir_val(dir_val),
        .rx_load(rx_load), .rx_byte(rx_data), .tx_done(tx_done)
    );

    i2cs_status u_stat (
        .clk(clk), .rst(rst), .ev_start(ev.start), .ev_stop(ev.stop),
        .dir_load(dir_load), .dir_val(dir_val), .rx_load(rx_load),
        .rx_rd(rx_rd), .tx_wr(tx_wr), .tx_byte_in(tx_data),
        .tx_done(tx_done), .st(st), .tx_buf(tx_buf)
    );

    assign stat_stop    = st.stop_seen;
    assign stat_start   = st.start_seen;
    assign stat_read    = st.read_dir;
    assign stat_rx_full = st.rx_full;
    assign stat_tx_full = st.tx_full;
endmodule

// File: tb/tb_i2cs_addr_status.sv
`timescale 1ns/1ps
module tb_i2cs_addr_status;
    localparam int Q = 8;
    localparam int H = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_pull_low, sda_bus;
    logic [6:0] own_addr = 7'h3A;
    logic mask_wr = 1'b0;
    logic [15:0] mask_wdata = '0, mask_rdata;
    logic rx_rd = 1'b0, tx_wr = 1'b0;
    logic [7:0] rx_data, tx_data = '0;
    logic stat_stop, stat_start, stat_read, stat_rx_full, stat_tx_full;
    int nvec = 0, nfail = 0;

    always #5 clk = ~clk;
    assign sda_bus = m_sda & ~sda_pull_low;

    i2cs_addr_status dut (
        .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_bus),
        .sda_pull_low(sda_pull_low), .own_addr(own_addr),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata), .mask_rdata(mask_rdata),
        .rx_rd(rx_rd), .rx_data(rx_data), .tx_wr(tx_wr), .tx_data(tx_data),
        .stat_stop(stat_stop), .stat_start(stat_start), .stat_read(stat_read),
        .stat_rx_full(stat_rx_full), .stat_tx_full(stat_tx_full)
    );

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; cyc(Q);
        m_scl = 1'b1; cyc(H);
        m_sda = 1'b0; cyc(H);
        m_scl = 1'b0; cyc(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; cyc(Q);
        m_scl = 1'b1; cyc(H);
        m_sda = 1'b1; cyc(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; cyc(Q);
            m_scl = 1'b1; cyc(H);
            m_scl = 1'b0; cyc(Q);
        end
        m_sda = 1'b1; cyc(Q);
        m_scl = 1'b1; cyc(H/2);
        acked = ~sda_bus;
        cyc(H/2);
        m_scl = 1'b0; cyc(Q);
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            cyc(Q);
            m_scl = 1'b1; cyc(H/2);
            b[i] = sda_bus;
            cyc(H/2);
            m_scl = 1'b0;
        end
        m_sda = ~give_ack; cyc(Q);
        m_scl = 1'b1; cyc(H);
        m_scl = 1'b0; cyc(Q);
        m_sda = 1'b1;
    endtask

    task automatic set_mask(input logic [15:0] v);
        mask_wdata = v; mask_wr = 1'b1; cyc(1);
        mask_wr = 1'b0; cyc(1);
    endtask

    task automatic probe_addr(input logic [6:0] a, input logic exp_ack, input string tag);
        logic ack;
        bus_start();
        send_byte({a, 1'b0}, ack);
        chk(tag, 16'(ack), 16'(exp_ack));
        bus_stop();
    endtask

    task automatic t_reset();
        chk("R10 stop flag", 16'(stat_stop), 16'h0);
        chk("R10 start flag", 16'(stat_start), 16'h0);
        chk("R10 read flag", 16'(stat_read), 16'h0);
        chk("R10 rx_full", 16'(stat_rx_full), 16'h0);
        chk("R10 tx_full", 16'(stat_tx_full), 16'h0);
        chk("R10 pull", 16'(sda_pull_low), 16'h0);
        chk("R10 mask", mask_rdata, 16'h0000);
    endtask

    task automatic t_mask_reg();
        set_mask(16'hFFFF);
        chk("R9 upper bits zero", mask_rdata, 16'h03FF);
        set_mask(16'hA5C3);
        chk("R9 readback", mask_rdata, 16'h01C3);
        set_mask(16'h0000);
    endtask

    task automatic t_write_match();
        logic ack;
        bus_start();
        chk("R2 start after Start", 16'(stat_start), 16'h1);
        chk("R1 stop after Start", 16'(stat_stop), 16'h0);
        send_byte(8'h74, ack);
        chk("R5 ack on exact match", 16'(ack), 16'h1);
        chk("R3 write dir", 16'(stat_read), 16'h0);
        send_byte(8'h5C, ack);
        chk("R7 data ack", 16'(ack), 16'h1);
        chk("R7 rx_full set", 16'(stat_rx_full), 16'h1);
        chk("R7 rx_data", 16'(rx_data), 16'h005C);
        rx_rd = 1'b1; cyc(1); rx_rd = 1'b0; cyc(1);
        chk("R7 rx_full cleared", 16'(stat_rx_full), 16'h0);
        send_byte(8'hE1, ack);
        chk("R7 second byte", 16'(rx_data), 16'h00E1);
        chk("R7 rx_full again", 16'(stat_rx_full), 16'h1);
        rx_rd = 1'b1; cyc(1); rx_rd = 1'b0; cyc(1);
        bus_stop();
        chk("R1 stop flag", 16'(stat_stop), 16'h1);
        chk("R2 start cleared by Stop", 16'(stat_start), 16'h0);
    endtask

    task automatic t_mismatch();
        logic ack;
        bus_start();
        send_byte(8'h77, ack);
        chk("R6 no ack on mismatch", 16'(ack), 16'h0);
        chk("R3 dir updated on mismatch", 16'(stat_read), 16'h1);
        send_byte(8'h33, ack);
        chk("R6 data ignored no ack", 16'(ack), 16'h0);
        chk("R6 rx_full stays 0", 16'(stat_rx_full), 16'h0);
        chk("R6 rx_data unchanged", 16'(rx_data), 16'h00E1);
        bus_stop();
    endtask

    task automatic t_masked();
        set_mask(16'h0003);
        probe_addr(7'h39, 1'b1, "R4 masked low bits match");
        probe_addr(7'h3E, 1'b0, "R4 unmasked bit2 differs");
        set_mask(16'h0380);
        probe_addr(7'h3A, 1'b1, "R4 upper mask bits harmless match");
        probe_addr(7'h7A, 1'b0, "R4 upper mask bits do not cover bit6");
        set_mask(16'h007F);
        probe_addr(7'h05, 1'b1, "R4 fully masked");
        set_mask(16'h0000);
    endtask

    task automatic t_read_restart();
        logic ack;
        logic [7:0] b;
        tx_data = 8'hA5; tx_wr = 1'b1; cyc(1); tx_wr = 1'b0; cyc(1);
        chk("R8 tx_full set", 16'(stat_tx_full), 16'h1);
        bus_start();
        send_byte(8'h74, ack);
        chk("R5 ack before restart", 16'(ack), 16'h1);
        chk("R3 write before restart", 16'(stat_read), 16'h0);
        bus_start();
        chk("R2 repeated start flag", 16'(stat_start), 16'h1);
        chk("R1 stop clear on repeated start", 16'(stat_stop), 16'h0);
        send_byte(8'h75, ack);
        chk("R5 ack read addr", 16'(ack), 16'h1);
        chk("R3 read dir", 16'(stat_read), 16'h1);
        chk("R8 tx_full before shift", 16'(stat_tx_full), 16'h1);
        get_byte(1'b0, b);
        chk("R8 read data", 16'(b), 16'h00A5);
        chk("R8 tx_full cleared", 16'(stat_tx_full), 16'h0);
        chk("R8 bus released after byte", 16'(sda_pull_low), 16'h0);
        bus_stop();
        chk("R1 stop after read", 16'(stat_stop), 16'h1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        cyc(4);
        rst = 1'b0;
        cyc(4);
        t_reset();
        t_mask_reg();
        t_write_match();
        t_mismatch();
        t_masked();
        t_read_restart();
        cyc(10);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule